// File: doc/BRIEF.md
# Client Message Crossbar

This block is a synchronous interconnect that links a fixed set of client modules, each known by an integer logical ID. Every client stages one 32-bit word per cycle, addressed by destination ID. The staged word is always shown to the destination one cycle later on a flowless exchange port. When the client also sets its queue-enable bit, the same word is pushed into the destination's receive FIFO. A client reads its own FIFO through a show-ahead port with empty and full flags.

Two more many-to-many paths run beside the point-to-point channels. The first is a shared control word. Each client drives its own contribution, by convention in a slice it owns, and every client reads the registered bitwise OR of all contributions. The second is a set of broadcast event lines. Any client may raise an event bit, and a client observes the resulting one-cycle pulse only where its subscription mask bit is set. When several clients address one destination in the same cycle, a fixed priority picks the lowest client ID. A FIFO writer that loses is told so by a one-cycle reject pulse.

Top module: `xbar_fabric`

## Requirements
- R1: A word staged by client s with destination field d (2 bits wide for four clients, value = target client ID) reaches only client d's exchange port and, when queued, only client d's receive FIFO.
- R2: Each receive FIFO delivers words in arrival order. The head is visible on rd_data while rd_empty is low. A word staged in cycle t becomes readable after the clock edge that ends cycle t+1, and asserting rd_en pops the head at the next edge.
- R3: A word staged in cycle t appears on xchg_data of its destination, with xchg_valid high, in cycle t+1 only, with no handshake.
- R4: A staged word with wr_fifo_en low still appears on the destination exchange port but is never written into any FIFO.
- R5: When several clients address the same destination in one cycle, the lowest client ID wins both the exchange port and the FIFO write. Every losing FIFO writer sees wr_reject high for exactly one cycle, one cycle after the exchange cycle.
- R6: Each receive FIFO holds 16 words and raises rd_full when it holds 16. A write to a full FIFO is dropped, and rd_en on an empty FIFO has no effect.
- R7: ctrl_shared equals the bitwise OR of all clients' ctrl_contrib values from the previous cycle.
- R8: Each cycle in which any client raises event bit e produces a one-cycle pulse on bit e of the event line in the next cycle. Client c sees the pulse on evt_seen only if bit e of its subscription mask is set.
- R9: Reset empties every FIFO and clears the staging registers, reject flags, shared control word and event lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | N_CLIENTS | Per-client staging request |
| wr_fifo_en | input | N_CLIENTS | Per-client request to also queue the staged word |
| wr_dest | input | N_CLIENTS*ID_W | Per-client destination ID |
| wr_data | input | N_CLIENTS*32 | Per-client staged word |
| wr_reject | output | N_CLIENTS | FIFO write lost arbitration |
| xchg_valid | output | N_CLIENTS | Exchange word present for this client |
| xchg_data | output | N_CLIENTS*32 | Exchange word for this client |
| rd_en | input | N_CLIENTS | Pop own receive FIFO |
| rd_data | output | N_CLIENTS*32 | Head of own receive FIFO |
| rd_empty | output | N_CLIENTS | Own FIFO empty |
| rd_full | output | N_CLIENTS | Own FIFO full |
| ctrl_contrib | input | N_CLIENTS*CTRL_W | Per-client contribution to the shared word |
| ctrl_shared | output | CTRL_W | Registered OR of all contributions |
| evt_raise | input | N_CLIENTS*EVT_W | Per-client event raise bits |
| evt_sub_mask | input | N_CLIENTS*EVT_W | Per-client subscription mask |
| evt_seen | output | N_CLIENTS*EVT_W | Masked event pulses per client |

## Verification
Several properties are checked on every cycle. The lowest client ID always reaches its destination's exchange port a cycle later. A reject pulse only follows a queued request. Every contributor's bits show up in the next shared control word. An event pulse is always preceded by a raise. A full FIFO stays full under a write with no pop, and an empty FIFO stays empty under a pop with no write. The scenarios cover what a single-cycle property cannot show:
- the arrival order and content of queued words across the FIFO;
- the 17th write that is dropped at depth 16;
- the exact winner and loser sets under contention;
- the per-client subscription masking;
- a reset in the middle of traffic that discards queued words.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    // Every point-to-point channel carries words of one uniform width.
    localparam int XB_DATA_W = 32;
    typedef logic [XB_DATA_W-1:0] xb_word_t;
endpackage

// File: rtl/xbar_rx_fifo.sv
module xbar_rx_fifo
    import xbar_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  xb_word_t wdata,
    input  logic     pop,
    output xb_word_t rdata,
    output logic     empty,
    output logic     full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0]   wp;
        logic [PW-1:0]   rp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    xb_word_t mem [DEPTH];
    logic     acc_push, acc_pop;

    always_comb begin
        st_d     = st_q;
        acc_push = push && (st_q.cnt < CNTW'(DEPTH));
        acc_pop  = pop && (st_q.cnt != '0);
        if (acc_push)
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (acc_pop)
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (acc_push && !acc_pop)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (!acc_push && acc_pop)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (acc_push) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNTW'(DEPTH));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(rdata)));
    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/xbar_dest_arb.sv
module xbar_dest_arb #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           req,
    input  logic [N*ID_W-1:0]      dest,
    output logic [N-1:0][N-1:0]    grant,
    output logic [N-1:0]           lose
);
    always_comb begin
        grant = '0;
        lose  = '0;
        for (int d = 0; d < N; d++) begin
            logic taken;
            taken = 1'b0;
            for (int s = 0; s < N; s++) begin
                if (req[s] && dest[s*ID_W +: ID_W] == ID_W'(d)) begin
                    if (!taken) begin
                        grant[d][s] = 1'b1;
                        taken       = 1'b1;
                    end else begin
                        lose[s] = 1'b1;
                    end
                end
            end
        end
    end

    for (genvar d = 0; d < N; d++) begin : g_chk
        // R5
        grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[d]));
    end
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
    import xbar_pkg::*;
#(
    parameter int  N_CLIENTS  = 4,
    parameter int  FIFO_DEPTH = 16,
    parameter int  CTRL_W     = 16,
    parameter int  EVT_W      = 4,
    localparam int ID_W       = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1,
    localparam int DW         = XB_DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CLIENTS-1:0]        wr_valid,
    input  logic [N_CLIENTS-1:0]        wr_fifo_en,
    input  logic [N_CLIENTS*ID_W-1:0]   wr_dest,
    input  logic [N_CLIENTS*DW-1:0]     wr_data,
    output logic [N_CLIENTS-1:0]        wr_reject,
    output logic [N_CLIENTS-1:0]        xchg_valid,
    output logic [N_CLIENTS*DW-1:0]     xchg_data,
    input  logic [N_CLIENTS-1:0]        rd_en,
    output logic [N_CLIENTS*DW-1:0]     rd_data,
    output logic [N_CLIENTS-1:0]        rd_empty,
    output logic [N_CLIENTS-1:0]        rd_full,
    input  logic [N_CLIENTS*CTRL_W-1:0] ctrl_contrib,
    output logic [CTRL_W-1:0]           ctrl_shared,
    input  logic [N_CLIENTS*EVT_W-1:0]  evt_raise,
    input  logic [N_CLIENTS*EVT_W-1:0]  evt_sub_mask,
    output logic [N_CLIENTS*EVT_W-1:0]  evt_seen
);
    typedef struct packed {
        logic            valid;
        logic            fifo_en;
        logic [ID_W-1:0] dest;
        xb_word_t        data;
    } stage_t;

    typedef struct packed {
        stage_t [N_CLIENTS-1:0] stg;
        logic   [N_CLIENTS-1:0] rej;
        logic   [CTRL_W-1:0]    ctrl;
        logic   [EVT_W-1:0]     evt;
    } fab_st_t;

    fab_st_t st_d, st_q;

    logic [N_CLIENTS-1:0]                xreq, freq, xlose, flose;
    logic [N_CLIENTS*ID_W-1:0]           stg_dest;
    logic [N_CLIENTS-1:0][N_CLIENTS-1:0] xgrant, fgrant;
    logic [N_CLIENTS-1:0]                push;
    logic [N_CLIENTS*DW-1:0]             push_data;

    always_comb begin
        for (int i = 0; i < N_CLIENTS; i++) begin
            xreq[i]                   = st_q.stg[i].valid;
            freq[i]                   = st_q.stg[i].valid && st_q.stg[i].fifo_en;
            stg_dest[i*ID_W +: ID_W]  = st_q.stg[i].dest;
        end
    end

    xbar_dest_arb #(.N(N_CLIENTS), .ID_W(ID_W)) u_xchg_arb (
        .clk(clk), .rst_n(rst_n), .req(xreq), .dest(stg_dest),
        .grant(xgrant), .lose(xlose)
    );

    xbar_dest_arb #(.N(N_CLIENTS), .ID_W(ID_W)) u_fifo_arb (
        .clk(clk), .rst_n(rst_n), .req(freq), .dest(stg_dest),
        .grant(fgrant), .lose(flose)
    );

    // Next-state: staging, reject flags, shared word and event lines.
    always_comb begin
        st_d      = st_q;
        st_d.ctrl = '0;
        st_d.evt  = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            st_d.stg[i].valid   = wr_valid[i];
            st_d.stg[i].fifo_en = wr_fifo_en[i];
            st_d.stg[i].dest    = wr_dest[i*ID_W +: ID_W];
            st_d.stg[i].data    = wr_data[i*DW +: DW];
            st_d.ctrl           = st_d.ctrl | ctrl_contrib[i*CTRL_W +: CTRL_W];
            st_d.evt            = st_d.evt | evt_raise[i*EVT_W +: EVT_W];
        end
        st_d.rej = flose;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Crossbar muxes from staging to each destination.
    always_comb begin
        xchg_valid = '0;
        xchg_data  = '0;
        push       = '0;
        push_data  = '0;
        for (int d = 0; d < N_CLIENTS; d++) begin
            for (int s = 0; s < N_CLIENTS; s++) begin
                if (xgrant[d][s]) begin
                    xchg_valid[d]         = 1'b1;
                    xchg_data[d*DW +: DW] = st_q.stg[s].data;
                end
                if (fgrant[d][s]) begin
                    push[d]               = 1'b1;
                    push_data[d*DW +: DW] = st_q.stg[s].data;
                end
            end
        end
    end

    for (genvar c = 0; c < N_CLIENTS; c++) begin : g_client
        xbar_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_rx (
            .clk(clk), .rst_n(rst_n),
            .push(push[c]), .wdata(push_data[c*DW +: DW]),
            .pop(rd_en[c]), .rdata(rd_data[c*DW +: DW]),
            .empty(rd_empty[c]), .full(rd_full[c])
        );
        assign evt_seen[c*EVT_W +: EVT_W] = st_q.evt & evt_sub_mask[c*EVT_W +: EVT_W];

        // R5
        reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_reject[c] |-> $past(st_q.stg[c].valid && st_q.stg[c].fifo_en));
        // R7
        ctrl_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((ctrl_shared & $past(ctrl_contrib[c*CTRL_W +: CTRL_W]))
                      == $past(ctrl_contrib[c*CTRL_W +: CTRL_W])));
        // R8
        evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_seen[c*EVT_W +: EVT_W]) |-> (|$past(evt_raise)));
        // R3
        xchg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_valid[0] && wr_dest[ID_W-1:0] == ID_W'(c))
            |-> (xchg_valid[c] && xchg_data[c*DW +: DW] == $past(wr_data[DW-1:0])));
    end

    assign wr_reject   = st_q.rej;
    assign ctrl_shared = st_q.ctrl;
endmodule

// File: tb/tb_xbar_fabric.sv
module tb_xbar_fabric;
    localparam int N = 4, DW = 32, CW = 16, EW = 4, DEPTH = 16, IDW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [N-1:0]      wr_valid, wr_fifo_en, rd_en, wr_reject, xchg_valid, rd_empty, rd_full;
    logic [N*IDW-1:0]  wr_dest;
    logic [N*DW-1:0]   wr_data, xchg_data, rd_data;
    logic [N*CW-1:0]   ctrl_contrib;
    logic [CW-1:0]     ctrl_shared;
    logic [N*EW-1:0]   evt_raise, evt_sub_mask, evt_seen;

    xbar_fabric #(.N_CLIENTS(N), .FIFO_DEPTH(DEPTH), .CTRL_W(CW), .EVT_W(EW)) dut (.*);

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_q [N][$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stage(input int src, input int dst, input logic [DW-1:0] d, input bit fen);
        wr_valid[src]             = 1'b1;
        wr_fifo_en[src]           = fen;
        wr_dest[src*IDW +: IDW]   = IDW'(dst);
        wr_data[src*DW +: DW]     = d;
    endtask

    // Driver: models lowest-ID-wins queueing and depth limit, then clocks the staging.
    task automatic fire();
        for (int d = 0; d < N; d++) begin
            bit done = 0;
            for (int s = 0; s < N; s++) begin
                if (!done && wr_valid[s] && wr_fifo_en[s] && wr_dest[s*IDW +: IDW] == IDW'(d)) begin
                    done = 1;
                    if (exp_q[d].size() < DEPTH) exp_q[d].push_back(wr_data[s*DW +: DW]);
                end
            end
        end
        tick();
        wr_valid   = '0;
        wr_fifo_en = '0;
    endtask

    // Monitor: pops the FIFO and compares each word with the scoreboard.
    task automatic drain(input int d, input string req);
        for (int k = 0; k < DEPTH + 4 && !rd_empty[d]; k++) begin
            if (exp_q[d].size() == 0) begin
                chk(0, req, rd_data[d*DW +: DW], 0);
            end else begin
                logic [DW-1:0] e = exp_q[d].pop_front();
                chk(rd_data[d*DW +: DW] == e, req, rd_data[d*DW +: DW], e);
            end
            rd_en[d] = 1'b1;
            tick();
            rd_en[d] = 1'b0;
        end
        chk(exp_q[d].size() == 0, req, exp_q[d].size(), 0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        rst_n = 0; wr_valid = '0; wr_fifo_en = '0; wr_dest = '0; wr_data = '0; rd_en = '0;
        ctrl_contrib = '0; evt_raise = '0; evt_sub_mask = '0;
        @(negedge clk); tick(); tick();
        // R9 reset state
        chk(rd_empty == 4'hF, "R9 empty", rd_empty, 4'hF);
        chk(rd_full == 0 && xchg_valid == 0 && wr_reject == 0, "R9 flags", {rd_full, xchg_valid, wr_reject}, 0);
        chk(ctrl_shared == 0 && evt_seen == 0, "R9 ctrl/evt", {ctrl_shared, evt_seen}, 0);
        rst_n = 1;
        tick();

        // R3 + R2: single queued word
        stage(1, 2, 32'hA5A5_0001, 1);
        fire();
        chk(xchg_valid == 4'b0100, "R3 valid", xchg_valid, 4'b0100);
        chk(xchg_data[2*DW +: DW] == 32'hA5A5_0001, "R3 data", xchg_data[2*DW +: DW], 32'hA5A5_0001);
        chk(rd_empty[2] == 1'b1, "R2 not yet", rd_empty[2], 1);
        tick();
        chk(xchg_valid == 0, "R3 one cycle", xchg_valid, 0);
        chk(rd_empty[2] == 1'b0, "R2 arrival", rd_empty[2], 0);
        drain(2, "R2 content");

        // R4: exchange without queueing
        stage(0, 3, 32'hDEAD_BEEF, 0);
        fire();
        chk(xchg_valid == 4'b1000 && xchg_data[3*DW +: DW] == 32'hDEAD_BEEF, "R4 xchg",
            xchg_data[3*DW +: DW], 32'hDEAD_BEEF);
        tick(); tick();
        chk(rd_empty == 4'hF, "R4 no queue", rd_empty, 4'hF);

        // R1: four concurrent routes
        stage(0, 1, 32'h1000_0001, 1);
        stage(1, 2, 32'h1000_0102, 1);
        stage(2, 3, 32'h1000_0203, 1);
        stage(3, 0, 32'h1000_0300, 1);
        fire();
        chk(xchg_valid == 4'hF, "R1 valid", xchg_valid, 4'hF);
        chk(xchg_data[0 +: DW] == 32'h1000_0300, "R1 route0", xchg_data[0 +: DW], 32'h1000_0300);
        chk(xchg_data[1*DW +: DW] == 32'h1000_0001, "R1 route1", xchg_data[1*DW +: DW], 32'h1000_0001);
        tick();
        chk(rd_empty == 4'h0 && wr_reject == 0, "R1 queued", {rd_empty, wr_reject}, 0);
        for (int d = 0; d < N; d++) drain(d, "R1 content");

        // R5: contention on destination 0
        stage(1, 0, 32'h0000_0111, 1);
        stage(3, 0, 32'h0000_0333, 1);
        fire();
        chk(xchg_data[0 +: DW] == 32'h0000_0111, "R5 xchg winner", xchg_data[0 +: DW], 32'h111);
        chk(wr_reject == 0, "R5 reject timing", wr_reject, 0);
        tick();
        chk(wr_reject == 4'b1000, "R5 reject", wr_reject, 4'b1000);
        tick();
        chk(wr_reject == 0, "R5 reject pulse", wr_reject, 0);
        drain(0, "R5 content");

        // R6: overfill client 3
        for (int k = 0; k < DEPTH + 1; k++) begin
            stage(0, 3, 32'h0000_1000 + k, 1);
            fire();
        end
        tick();
        chk(rd_full[3] == 1'b1, "R6 full", rd_full[3], 1);
        drain(3, "R6 order/drop");
        chk(rd_full[3] == 0 && rd_empty[3] == 1, "R6 after drain", {rd_full[3], rd_empty[3]}, 2'b01);
        rd_en[0] = 1'b1;
        tick();
        rd_en[0] = 1'b0;
        chk(rd_empty[0] == 1'b1, "R6 pop empty", rd_empty[0], 1);
        stage(2, 0, 32'hCAFE_0000, 1);
        fire();
        tick();
        drain(0, "R6 pop empty ignored");

        // R7: shared control word
        ctrl_contrib = {16'h0000, 16'h0F00, 16'h00F0, 16'h000F};
        tick();
        chk(ctrl_shared == 16'h0FFF, "R7 slices", ctrl_shared, 16'h0FFF);
        ctrl_contrib[3*CW +: CW] = 16'h8001;
        tick();
        chk(ctrl_shared == 16'h8FFF, "R7 overlap", ctrl_shared, 16'h8FFF);
        ctrl_contrib = '0;
        tick();
        chk(ctrl_shared == 0, "R7 clear", ctrl_shared, 0);

        // R8: events with masks
        evt_sub_mask = {4'b0000, 4'b1111, 4'b0010, 4'b0001};
        evt_raise[3*EW +: EW] = 4'b0011;
        tick();
        evt_raise = '0;
        chk(evt_seen == {4'b0000, 4'b0011, 4'b0010, 4'b0001}, "R8 masked", evt_seen,
            {4'b0000, 4'b0011, 4'b0010, 4'b0001});
        tick();
        chk(evt_seen == 0, "R8 pulse", evt_seen, 0);

        // R9: reset during traffic
        stage(2, 1, 32'h0000_0077, 1);
        fire();
        ctrl_contrib[0 +: CW] = 16'h0005;
        tick();
        chk(rd_empty[1] == 0, "R9 pre", rd_empty[1], 0);
        rst_n = 0;
        ctrl_contrib = '0;
        tick();
        chk(rd_empty[1] == 1 && ctrl_shared == 0, "R9 mid reset", {rd_empty[1], ctrl_shared}, 1);
        exp_q[1].delete();
        rst_n = 1;
        tick();
        chk(rd_empty == 4'hF && xchg_valid == 0, "R9 after", {rd_empty, xchg_valid}, 8'hF0);

        report();
    end
endmodule